// File: doc/BRIEF.md
# Return-Address Stack with Vectored Interrupt Entry

This block keeps the return addresses for a 16-bit program counter in a small hardware stack that grows upward. A call strobe saves the current PC on the stack and hands the subroutine target back to the fetch logic as the next PC. A return strobe takes the newest saved PC off the stack and hands it back. The stack has a fixed number of entries, so the nesting depth is limited. When the stack is full, a push is refused and an overflow pulse is raised. When the stack is empty, a pop is refused and an underflow pulse is raised.

Interrupts share the same stack. At an instruction boundary, a pending request that is not masked saves the PC, just as a call does. The new PC comes from a four-entry vector table, one entry per request source, and the table is written through a simple write port. Taking an interrupt sets an interrupt-disable mask. The mask is cleared only by a return-from-interrupt strobe.

Every result is registered. One cycle after the cause, a one-cycle `pcLoad` pulse presents the new PC on `pcOut`.

Top module: `callstack_unit`

## Requirements
- R1: After reset, `pcLoad`, `overflow`, `underflow` and `intDisable` are all 0, and the stack is empty.
- R2: A call (`callStb`=1) on an edge pushes `pcIn`. In the following cycle `pcLoad`=1 and `pcOut` equals `target`.
- R3: A return (`retStb`=1) pops the newest entry. In the following cycle `pcLoad`=1 and `pcOut` equals the value pushed last, so entries come back in last-in first-out order.
- R4: The stack holds 8 entries. A push while 8 entries are held gives `overflow`=1 for one cycle and `pcLoad`=0, and leaves the stack contents unchanged.
- R5: A return or return-from-interrupt while the stack is empty gives `underflow`=1 for one cycle and `pcLoad`=0, and leaves `intDisable` unchanged.
- R6: An interrupt is taken on an edge only when all of the following hold: `boundary`=1, `intDisable`=0, at least one bit of `irqReq` is set, and no call, return or return-from-interrupt strobe is active. Taking it pushes `pcIn`. In the following cycle `pcLoad`=1, `pcOut` equals the vector of the winning source, and `intDisable`=1.
- R7: Source n is bit n of `irqReq`. The lowest-numbered pending source wins. A write with `vecWe`=1 stores `vecData` as the vector of source `vecIdx`.
- R8: Requests are ignored while `intDisable`=1 or while `boundary`=0.
- R9: A return-from-interrupt (`retiStb`=1) pops like a return and clears `intDisable`. A plain return leaves `intDisable` unchanged.
- R10: When several strobes arrive together, call beats return, and return beats return-from-interrupt. Any of these strobes keeps an interrupt from being taken in that cycle.
- R11: An interrupt that would otherwise be taken while the stack is full gives `overflow`=1 and `pcLoad`=0, and leaves `intDisable` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcIn | input | 16 | PC to save on a push |
| callStb | input | 1 | Call strobe |
| retStb | input | 1 | Return strobe |
| retiStb | input | 1 | Return-from-interrupt strobe |
| target | input | 16 | Subroutine address for a call |
| boundary | input | 1 | Instruction-boundary strobe |
| irqReq | input | 4 | Interrupt request lines, bit n is source n |
| vecWe | input | 1 | Vector table write enable |
| vecIdx | input | 2 | Vector table entry to write |
| vecData | input | 16 | Vector address to write |
| pcOut | output | 16 | New PC |
| pcLoad | output | 1 | One-cycle pulse: `pcOut` is valid |
| intDisable | output | 1 | Interrupt-disable mask |
| overflow | output | 1 | One-cycle pulse: a push was refused |
| underflow | output | 1 | One-cycle pulse: a pop was refused |

## Verification
A wrong stack pointer or a corrupted entry does not show at once. It shows at the first return that reaches the bad entry. The wrong value appears on `pcOut` one cycle after that return, or `overflow` or `underflow` fires one push or pop early or late. The tests therefore fill the stack to its limit and then drain it, checking every popped value and the refused access at each end. A wrong mask state shows at the next boundary that has a request pending. It either takes an interrupt that should be blocked or misses one that should be taken, and `pcLoad` shows this one cycle later.

// File: rtl/callstack_pkg.sv
package callstack_pkg;
  parameter int PC_W    = 16;
  parameter int DEPTH   = 8;
  parameter int NUM_SRC = 4;
  localparam int SP_W   = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SRC_W  = $clog2(NUM_SRC);

  typedef struct packed {
    logic             push;
    logic             pop;
    logic             useVector;
    logic [SRC_W-1:0] srcSel;
    logic             ovf;
    logic             unf;
  } stackCmd_t;
endpackage

// File: rtl/callstack_ctrl.sv
module callstack_ctrl
  import callstack_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               callStb,
  input  logic               retStb,
  input  logic               retiStb,
  input  logic               boundary,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               stackFull,
  input  logic               stackEmpty,
  output stackCmd_t          cmd,
  output logic               maskOut
);
  logic             maskQ;
  logic             anyReq;
  logic [SRC_W-1:0] winIdx;
  logic             takeIrq;
  logic             setMask;
  logic             clrMask;

  // lowest-numbered pending source wins
  always_comb begin
    anyReq = |irqReq;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (irqReq[i]) winIdx = SRC_W'(i);
    end
  end

  assign takeIrq = boundary && !maskQ && anyReq && !callStb && !retStb && !retiStb;

  always_comb begin
    cmd     = '0;
    setMask = 1'b0;
    clrMask = 1'b0;
    if (callStb) begin
      cmd.push = !stackFull;
      cmd.ovf  = stackFull;
    end else if (retStb) begin
      cmd.pop = !stackEmpty;
      cmd.unf = stackEmpty;
    end else if (retiStb) begin
      cmd.pop = !stackEmpty;
      cmd.unf = stackEmpty;
      clrMask = !stackEmpty;
    end else if (takeIrq) begin
      cmd.push      = !stackFull;
      cmd.ovf       = stackFull;
      cmd.useVector = 1'b1;
      cmd.srcSel    = winIdx;
      setMask       = !stackFull;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        maskQ <= 1'b0;
    else if (setMask) maskQ <= 1'b1;
    else if (clrMask) maskQ <= 1'b0;
  end

  assign maskOut = maskQ;
endmodule

// File: rtl/callstack_dp.sv
module callstack_dp
  import callstack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stackCmd_t        cmd,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [PC_W-1:0]  target,
  input  logic             vecWe,
  input  logic [SRC_W-1:0] vecIdx,
  input  logic [PC_W-1:0]  vecData,
  output logic             stackFull,
  output logic             stackEmpty,
  output logic [PC_W-1:0]  pcOut,
  output logic             pcLoad,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [SP_W-1:0] FULL_LVL = SP_W'(DEPTH);

  logic [SP_W-1:0]  sp;
  logic [PC_W-1:0]  mem [DEPTH];
  logic [PC_W-1:0]  vecTab [NUM_SRC];
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdPtr;
  logic [PC_W-1:0]  pushDest;

  assign stackFull  = (sp == FULL_LVL);
  assign stackEmpty = (sp == '0);
  assign wrPtr      = sp[IDX_W-1:0];
  assign rdPtr      = IDX_W'(sp - 1'b1);
  assign pushDest   = cmd.useVector ? vecTab[cmd.srcSel] : target;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gVec
      always_ff @(posedge clk) begin
        if (!rstN)                             vecTab[g] <= '0;
        else if (vecWe && vecIdx == SRC_W'(g)) vecTab[g] <= vecData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= pcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp        <= '0;
      pcOut     <= '0;
      pcLoad    <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      pcLoad    <= cmd.push || cmd.pop;
      overflow  <= cmd.ovf;
      underflow <= cmd.unf;
      if (cmd.push) begin
        sp    <= sp + 1'b1;
        pcOut <= pushDest;
      end else if (cmd.pop) begin
        sp    <= sp - 1'b1;
        pcOut <= mem[rdPtr];
      end
    end
  end
endmodule

// File: rtl/callstack_unit.sv
module callstack_unit
  import callstack_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PC_W-1:0]    pcIn,
  input  logic               callStb,
  input  logic               retStb,
  input  logic               retiStb,
  input  logic [PC_W-1:0]    target,
  input  logic               boundary,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               vecWe,
  input  logic [SRC_W-1:0]   vecIdx,
  input  logic [PC_W-1:0]    vecData,
  output logic [PC_W-1:0]    pcOut,
  output logic               pcLoad,
  output logic               intDisable,
  output logic               overflow,
  output logic               underflow
);
  stackCmd_t cmd;
  logic      stackFull;
  logic      stackEmpty;

  callstack_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .callStb(callStb), .retStb(retStb),
    .retiStb(retiStb), .boundary(boundary), .irqReq(irqReq),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .cmd(cmd),
    .maskOut(intDisable)
  );

  callstack_dp uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pcIn(pcIn), .target(target),
    .vecWe(vecWe), .vecIdx(vecIdx), .vecData(vecData),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .pcOut(pcOut),
    .pcLoad(pcLoad), .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: rtl/callstack_chk.sv
module callstack_chk
  import callstack_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               callStb,
  input logic               retStb,
  input logic               retiStb,
  input logic [PC_W-1:0]    target,
  input logic               boundary,
  input logic [PC_W-1:0]    pcOut,
  input logic               pcLoad,
  input logic               intDisable,
  input logic               overflow,
  input logic               underflow
);
  // R2
  call_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    callStb |=> (overflow || (pcLoad && pcOut == $past(target))));

  // R4
  no_overflow_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !pcLoad);

  // R5
  no_underflow_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> !pcLoad);

  // R6
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intDisable) |-> pcLoad);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!boundary && !callStb && !retStb && !retiStb) |=> !pcLoad);

  // R9
  ret_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStb && !callStb) |=> (intDisable == $past(intDisable)));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));
endmodule

bind callstack_unit callstack_chk uChk (
  .clk(clk), .rstN(rstN), .callStb(callStb), .retStb(retStb),
  .retiStb(retiStb), .target(target), .boundary(boundary), .pcOut(pcOut),
  .pcLoad(pcLoad), .intDisable(intDisable), .overflow(overflow),
  .underflow(underflow)
);

// File: tb/callstack_unit_test.sv
module callstack_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pcIn = '0;
  logic        callStb = 1'b0;
  logic        retStb = 1'b0;
  logic        retiStb = 1'b0;
  logic [15:0] target = '0;
  logic        boundary = 1'b0;
  logic [3:0]  irqReq = '0;
  logic        vecWe = 1'b0;
  logic [1:0]  vecIdx = '0;
  logic [15:0] vecData = '0;
  logic [15:0] pcOut;
  logic        pcLoad;
  logic        intDisable;
  logic        overflow;
  logic        underflow;

  int nChecks = 0;
  int nFails  = 0;

  callstack_unit uut (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .callStb(callStb), .retStb(retStb),
    .retiStb(retiStb), .target(target), .boundary(boundary), .irqReq(irqReq),
    .vecWe(vecWe), .vecIdx(vecIdx), .vecData(vecData), .pcOut(pcOut),
    .pcLoad(pcLoad), .intDisable(intDisable), .overflow(overflow),
    .underflow(underflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] vecOf(input int s);
    return 16'h8000 + 16'(s) * 16'h0100;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive strobes after a falling edge, let one rising edge sample them, clear on the next falling edge
  task automatic op(input logic c, input logic r, input logic ri, input logic b,
                    input logic [3:0] irq, input logic [15:0] tg, input logic [15:0] pc);
    callStb = c; retStb = r; retiStb = ri; boundary = b; irqReq = irq; target = tg; pcIn = pc;
    @(posedge clk);
    @(negedge clk);
    callStb = 0; retStb = 0; retiStb = 0; boundary = 0; irqReq = '0;
  endtask

  task automatic expLoad(input string req, input logic [15:0] pc);
    chk(req, "pcLoad", 16'(pcLoad), 16'd1);
    chk(req, "pcOut", pcOut, pc);
  endtask

  task automatic t_reset();
    chk("R1", "pcLoad", 16'(pcLoad), 0);
    chk("R1", "overflow", 16'(overflow), 0);
    chk("R1", "underflow", 16'(underflow), 0);
    chk("R1", "intDisable", 16'(intDisable), 0);
    op(0, 1, 0, 0, 0, 0, 0);
    chk("R1", "empty stack underflow", 16'(underflow), 1);
  endtask

  task automatic t_vectors();
    for (int s = 0; s < 4; s++) begin
      vecWe = 1; vecIdx = 2'(s); vecData = vecOf(s);
      @(posedge clk);
      @(negedge clk);
    end
    vecWe = 0;
  endtask

  task automatic t_callRet();
    op(1, 0, 0, 0, 0, 16'h0200, 16'h0010); expLoad("R2", 16'h0200);
    op(1, 0, 0, 0, 0, 16'h0300, 16'h0203); expLoad("R2", 16'h0300);
    op(0, 1, 0, 0, 0, 0, 0); expLoad("R3", 16'h0203);
    op(0, 1, 0, 0, 0, 0, 0); expLoad("R3", 16'h0010);
    op(0, 1, 0, 0, 0, 0, 0);
    chk("R5", "underflow", 16'(underflow), 1);
    chk("R5", "pcLoad", 16'(pcLoad), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) begin
      op(1, 0, 0, 0, 0, 16'h4000 + 16'(i), 16'h0100 + 16'(i));
      expLoad("R4", 16'h4000 + 16'(i));
    end
    op(1, 0, 0, 0, 0, 16'h5555, 16'h0bad);
    chk("R4", "overflow", 16'(overflow), 1);
    chk("R4", "pcLoad", 16'(pcLoad), 0);
    for (int i = 7; i >= 0; i--) begin
      op(0, 1, 0, 0, 0, 0, 0);
      expLoad("R4", 16'h0100 + 16'(i));
    end
    op(0, 1, 0, 0, 0, 0, 0);
    chk("R5", "underflow after drain", 16'(underflow), 1);
  endtask

  task automatic t_irq();
    op(0, 0, 0, 1, 4'b0110, 0, 16'h0444);
    expLoad("R7", vecOf(1));
    chk("R6", "intDisable", 16'(intDisable), 1);
    op(0, 0, 0, 1, 4'b0001, 0, 16'h8100);
    chk("R8", "masked pcLoad", 16'(pcLoad), 0);
    op(1, 0, 0, 0, 0, 16'h9000, 16'h8102); expLoad("R2", 16'h9000);
    op(0, 1, 0, 0, 0, 0, 0); expLoad("R9", 16'h8102);
    chk("R9", "ret keeps mask", 16'(intDisable), 1);
    op(0, 0, 1, 0, 0, 0, 0); expLoad("R9", 16'h0444);
    chk("R9", "reti clears mask", 16'(intDisable), 0);
  endtask

  task automatic t_boundary();
    op(0, 0, 0, 0, 4'b0001, 0, 16'h0600);
    chk("R8", "no boundary pcLoad", 16'(pcLoad), 0);
    chk("R8", "no boundary mask", 16'(intDisable), 0);
    op(0, 0, 0, 1, 4'b1000, 0, 16'h0601);
    expLoad("R7", vecOf(3));
    op(0, 0, 1, 0, 0, 0, 0); expLoad("R9", 16'h0601);
  endtask

  task automatic t_precedence();
    op(0, 0, 0, 1, 4'b0001, 0, 16'h0700); expLoad("R6", vecOf(0));
    op(1, 1, 0, 1, 4'b0001, 16'h5000, 16'h8001); expLoad("R10", 16'h5000);
    chk("R10", "no underflow", 16'(underflow), 0);
    op(0, 1, 1, 0, 0, 0, 0); expLoad("R10", 16'h8001);
    chk("R10", "ret beats reti mask", 16'(intDisable), 1);
    op(0, 0, 1, 0, 0, 0, 0); expLoad("R9", 16'h0700);
    op(1, 0, 0, 1, 4'b0100, 16'h6000, 16'h0800); expLoad("R10", 16'h6000);
    chk("R10", "call blocks irq", 16'(intDisable), 0);
    op(0, 0, 0, 1, 4'b0100, 0, 16'h6001); expLoad("R10", vecOf(2));
    op(0, 0, 1, 0, 0, 0, 0); expLoad("R9", 16'h6001);
    op(0, 1, 0, 0, 0, 0, 0); expLoad("R3", 16'h0800);
    // plain return empties the stack under mask; reti on empty keeps the mask
    op(0, 0, 0, 1, 4'b0001, 0, 16'h0900); expLoad("R6", vecOf(0));
    op(0, 1, 0, 0, 0, 0, 0); expLoad("R3", 16'h0900);
    op(0, 0, 1, 0, 0, 0, 0);
    chk("R5", "reti empty underflow", 16'(underflow), 1);
    chk("R5", "reti empty keeps mask", 16'(intDisable), 1);
    op(1, 0, 0, 0, 0, 16'h0a00, 16'h0a01); expLoad("R2", 16'h0a00);
    op(0, 0, 1, 0, 0, 0, 0); expLoad("R9", 16'h0a01);
    chk("R9", "mask cleared", 16'(intDisable), 0);
  endtask

  task automatic t_irqFull();
    for (int i = 0; i < 8; i++) op(1, 0, 0, 0, 0, 16'h7000, 16'h0c00 + 16'(i));
    op(0, 0, 0, 1, 4'b0001, 0, 16'h0cff);
    chk("R11", "overflow", 16'(overflow), 1);
    chk("R11", "pcLoad", 16'(pcLoad), 0);
    chk("R11", "intDisable", 16'(intDisable), 0);
    for (int i = 7; i >= 0; i--) begin
      op(0, 1, 0, 0, 0, 0, 0);
      expLoad("R11", 16'h0c00 + 16'(i));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_callRet();
    t_overflow();
    t_irq();
    t_boundary();
    t_precedence();
    t_irqFull();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule